// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is the host-side controller for one external memory bank plus one external I/O region. A requester inside the chip hands it a single read, a single write, or a four-beat burst, and the block runs the external cycle: chip select, output enable, write enable, address lines and data lines. It finishes with a one-cycle completion pulse. Read data comes back with a valid strobe for each beat. Write data is pulled from the requester one word per beat through an acknowledge strobe.

The bank can run with a separate address bus or with a shared one. When multiplexing is on, the first cycle of each bank access puts the address on the data lines and every later cycle carries data. A burst has only that single address cycle, so the attached device has to count beats by itself. The controller tells the device that a burst is coming by driving address bit 21 high in the address cycle. No address strobe is generated, so the device must recognise the address cycle from the enables. An active-low wait input can stretch data cycles. On the bank this only happens when wait is enabled. The I/O region always honours it.

Top module: `mux_bus_master`

## Requirements
- R1: With `mux_en_i` high at acceptance and `req_io_i` low, the first cycle after acceptance is an address cycle. In that cycle `bank_cs_n_o` is low, `oe_n_o` and `we_n_o` are high, `bus_dq_oe_o` is high, and `bus_dq_o[21:0]` carries the address. Data cycles follow.
- R2: With `mux_en_i` low, there is no address cycle. The first cycle after acceptance is already a data cycle, and in each data cycle `bus_addr_o` equals the request address plus the beat index (0..3).
- R3: A burst (`req_burst_i`=1) completes exactly four data beats and a single access completes one. In multiplexed mode a burst has exactly one address cycle, and `bus_addr_o` holds its address-cycle value for the whole access.
- R4: In multiplexed mode, bit 21 of both `bus_addr_o` and `bus_dq_o` is 1 in the address cycle of a burst and 0 in the address cycle of a single access, whatever bit 21 of the request address is.
- R5: On the bank with `wait_en_i`=1, every data cycle that ends with `ext_wait_ni` low at the rising edge is repeated, and all bus outputs stay unchanged. The address cycle is never stretched.
- R6: On the bank with `wait_en_i`=0, `ext_wait_ni` has no effect: every data cycle completes a beat.
- R7: An I/O request (`req_io_i`=1) drives `io_cs_n_o` instead of `bank_cs_n_o`. It never has an address cycle, whatever the value of `mux_en_i`, and it honours `ext_wait_ni` as in R5 whatever the value of `wait_en_i`.
- R8: For reads, `rvalid_o` pulses in the cycle after each beat completes, with `rdata_o` holding the `bus_dq_i` value sampled at that edge. The beats come in order.
- R9: `done_o` is a one-cycle pulse in the cycle after the final beat completes. `ready_o` is high in that cycle, and for reads it coincides with the last `rvalid_o`.
- R10: In write data cycles, `we_n_o` is low, `bus_dq_oe_o` is high and `bus_dq_o` carries beat k's word. Word 0 is taken from `req_wdata_i` at acceptance and word k+1 at the edge where `wdata_ack_o` marks beat k done. In read data cycles, `oe_n_o` is low and `bus_dq_oe_o` is low.
- R11: After reset, `ready_o` is high, both chip selects and both enables are high, and `bus_dq_oe_o`, `rvalid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_en_i | input | 1 | Multiplexed mode for the bank, sampled at acceptance |
| wait_en_i | input | 1 | Lets the wait input stretch bank cycles, sampled at acceptance |
| req_i | input | 1 | Request; accepted when `ready_o` is high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = four-beat burst |
| req_io_i | input | 1 | 1 = I/O region, 0 = bank |
| req_addr_i | input | AW (22) | Word address |
| req_wdata_i | input | DW (32) | Next write word |
| ready_o | output | 1 | Controller idle |
| wdata_ack_o | output | 1 | Write beat done; `req_wdata_i` is taken at this edge |
| rdata_o | output | DW | Read beat data |
| rvalid_o | output | 1 | Read beat valid |
| done_o | output | 1 | Access complete pulse |
| bank_cs_n_o | output | 1 | Bank chip select, active low |
| io_cs_n_o | output | 1 | I/O chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| bus_addr_o | output | AW | External address lines |
| bus_dq_o | output | DW | Outgoing data lines |
| bus_dq_oe_o | output | 1 | Drive enable for `bus_dq_o` |
| bus_dq_i | input | DW | Incoming data lines |
| ext_wait_ni | input | 1 | External wait, active low |

## Verification
The wait input and the multiplexed address cycle can fall in the same cycle. Wait may also be active in the final data beat, which delays the completion pulse that would otherwise come next. Random wait patterns are driven every cycle, with no regard to phase, so wait lands on address cycles as well as on last beats. Each access is judged by counting chip-select cycles against one address cycle plus the beat count plus only those wait cycles that fell in data cycles of a waiting target. Completion is also checked to land together with the last read strobe.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic we;
    logic burst;
    logic io;
    logic mux;
    logic wait_en;
  } acc_cfg_t;
endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
#(
  parameter int unsigned AW        = 22,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  acc_cfg_t      cfg_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ext_wait_ni,
  output phase_e        phase_o,
  output acc_cfg_t      cfg_o,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] beat_o,
  output logic          accept_o,
  output logic          stall_o,
  output logic          beat_done_o,
  output logic          last_o
);
  phase_e        phase_q;
  acc_cfg_t      cfg_q, cfg_n;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] beat_q;

  // I/O region is never multiplexed
  always_comb begin
    cfg_n     = cfg_i;
    cfg_n.mux = cfg_i.mux & ~cfg_i.io;
  end

  assign accept_o    = req_i && (phase_q == PH_IDLE);
  assign stall_o     = (phase_q == PH_DATA) && !ext_wait_ni && (cfg_q.wait_en || cfg_q.io);
  assign beat_done_o = (phase_q == PH_DATA) && !stall_o;
  assign last_o      = cfg_q.burst ? (beat_q == BW'(BURST_LEN - 1)) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cfg_q   <= '0;
      addr_q  <= '0;
      beat_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept_o) begin
          cfg_q   <= cfg_n;
          addr_q  <= addr_i;
          beat_q  <= '0;
          phase_q <= cfg_n.mux ? PH_ADDR : PH_DATA;
        end
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: if (beat_done_o) begin
          if (last_o) phase_q <= PH_IDLE;
          else        beat_q  <= beat_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cfg_o   = cfg_q;
  assign addr_o  = addr_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/mbm_drive.sv
module mbm_drive
  import mbm_pkg::*;
#(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 32,
  parameter int unsigned BW        = 2,
  parameter int unsigned BURST_BIT = 21
) (
  input  phase_e        phase_i,
  input  logic          we_i,
  input  logic          burst_i,
  input  logic          io_i,
  input  logic          mux_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] beat_i,
  input  logic [DW-1:0] wdata_i,
  output logic          bank_cs_n_o,
  output logic          io_cs_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe_o
);
  logic [AW-1:0] addr_flag;
  logic          active, in_data;

  // burst flag overrides one address line in the address cycle
  always_comb begin
    addr_flag            = addr_i;
    addr_flag[BURST_BIT] = burst_i;
  end

  assign active  = (phase_i != PH_IDLE);
  assign in_data = (phase_i == PH_DATA);

  assign bank_cs_n_o = !(active && !io_i);
  assign io_cs_n_o   = !(active && io_i);
  assign oe_n_o      = !(in_data && !we_i);
  assign we_n_o      = !(in_data && we_i);
  assign bus_dq_oe_o = (phase_i == PH_ADDR) || (in_data && we_i);

  always_comb begin
    if (!active)    bus_addr_o = '0;
    else if (mux_i) bus_addr_o = addr_flag;
    else            bus_addr_o = addr_i + AW'(beat_i);
  end

  always_comb begin
    if (phase_i == PH_ADDR)   bus_dq_o = DW'(addr_flag);
    else if (in_data && we_i) bus_dq_o = wdata_i;
    else                      bus_dq_o = '0;
  end
endmodule

// File: rtl/mbm_data.sv
module mbm_data #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          beat_done_i,
  input  logic          last_i,
  input  logic          we_i,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] wdata_o,
  output logic          wdata_ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          done_o
);
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q, done_q;

  assign wdata_ack_o = beat_done_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (accept_i || wdata_ack_o) wdata_q <= req_wdata_i;
      rvalid_q <= beat_done_i && !we_i;
      if (beat_done_i && !we_i) rdata_q <= dq_i;
      done_q <= beat_done_i && last_i;
    end
  end

  assign wdata_o  = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign done_o   = done_q;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 32,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned BURST_BIT = 21,
  localparam int unsigned BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_en_i,
  input  logic          wait_en_i,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_burst_i,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ready_o,
  output logic          wdata_ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          done_o,
  output logic          bank_cs_n_o,
  output logic          io_cs_n_o,
  output logic          oe_n_o,
  output logic          we_n_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe_o,
  input  logic [DW-1:0] bus_dq_i,
  input  logic          ext_wait_ni
);
  acc_cfg_t      req_cfg, cfg_q;
  phase_e        phase;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] beat;
  logic [DW-1:0] wdata_q;
  logic          accept, stall, beat_done, last_beat;

  assign req_cfg = '{we: req_we_i, burst: req_burst_i, io: req_io_i,
                     mux: mux_en_i, wait_en: wait_en_i};

  mbm_seq #(.AW(AW), .BURST_LEN(BURST_LEN)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .cfg_i       (req_cfg),
    .addr_i      (req_addr_i),
    .ext_wait_ni (ext_wait_ni),
    .phase_o     (phase),
    .cfg_o       (cfg_q),
    .addr_o      (addr_q),
    .beat_o      (beat),
    .accept_o    (accept),
    .stall_o     (stall),
    .beat_done_o (beat_done),
    .last_o      (last_beat)
  );

  mbm_drive #(.AW(AW), .DW(DW), .BW(BW), .BURST_BIT(BURST_BIT)) i_drive (
    .phase_i     (phase),
    .we_i        (cfg_q.we),
    .burst_i     (cfg_q.burst),
    .io_i        (cfg_q.io),
    .mux_i       (cfg_q.mux),
    .addr_i      (addr_q),
    .beat_i      (beat),
    .wdata_i     (wdata_q),
    .bank_cs_n_o (bank_cs_n_o),
    .io_cs_n_o   (io_cs_n_o),
    .oe_n_o      (oe_n_o),
    .we_n_o      (we_n_o),
    .bus_addr_o  (bus_addr_o),
    .bus_dq_o    (bus_dq_o),
    .bus_dq_oe_o (bus_dq_oe_o)
  );

  mbm_data #(.DW(DW)) i_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .beat_done_i (beat_done),
    .last_i      (last_beat),
    .we_i        (cfg_q.we),
    .dq_i        (bus_dq_i),
    .req_wdata_i (req_wdata_i),
    .wdata_o     (wdata_q),
    .wdata_ack_o (wdata_ack_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .done_o      (done_o)
  );

  assign ready_o = (phase == PH_IDLE);

  logic unused_stall;
  assign unused_stall = stall;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker
  import mbm_pkg::*;
#(
  parameter int unsigned AW        = 22,
  parameter int unsigned DW        = 32,
  parameter int unsigned BURST_BIT = 21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input phase_e        phase_i,
  input acc_cfg_t      cfg_i,
  input logic          mux_en_i,
  input logic          req_i,
  input logic          req_io_i,
  input logic [AW-1:0] req_addr_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          done_o,
  input logic          bank_cs_n_o,
  input logic          io_cs_n_o,
  input logic          oe_n_o,
  input logic          we_n_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_dq_o,
  input logic          bus_dq_oe_o,
  input logic          ext_wait_ni
);
  logic wait_hit;
  assign wait_hit = (phase_i == PH_DATA) && !ext_wait_ni && (cfg_i.wait_en || cfg_i.io);

  p_addr_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_ADDR) |-> (!bank_cs_n_o && oe_n_o && we_n_o && bus_dq_oe_o
                              && bus_dq_o[AW-1:0] == bus_addr_o));

  p_addr_then_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_ADDR) |=> (phase_i == PH_DATA));

  p_no_addr_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !(mux_en_i && !req_io_i))
      |=> (phase_i == PH_DATA && bus_addr_o == $past(req_addr_i)));

  p_burst_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_ADDR) |-> (bus_addr_o[BURST_BIT] == cfg_i.burst
                              && bus_dq_o[BURST_BIT] == cfg_i.burst));

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_hit |=> ($stable(bus_addr_o) && $stable(bus_dq_o) && $stable(bus_dq_oe_o)
                  && $stable(oe_n_o) && $stable(we_n_o) && $stable(bank_cs_n_o)
                  && $stable(io_cs_n_o) && !rvalid_o && !done_o));

  p_wait_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_DATA && !cfg_i.io && !cfg_i.wait_en && !cfg_i.we) |=> rvalid_o);

  p_io_plain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_cs_n_o |-> (phase_i != PH_ADDR));

  p_one_select_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!io_cs_n_o && !bank_cs_n_o));

  p_done_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_read_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> (!bus_dq_oe_o && we_n_o));

  p_write_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (bus_dq_oe_o && oe_n_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (bank_cs_n_o && io_cs_n_o && oe_n_o && we_n_o && !bus_dq_oe_o));
endmodule

bind mux_bus_master mbm_checker #(.AW(AW), .DW(DW), .BURST_BIT(BURST_BIT)) i_mbm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_i     (phase),
  .cfg_i       (cfg_q),
  .mux_en_i    (mux_en_i),
  .req_i       (req_i),
  .req_io_i    (req_io_i),
  .req_addr_i  (req_addr_i),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .done_o      (done_o),
  .bank_cs_n_o (bank_cs_n_o),
  .io_cs_n_o   (io_cs_n_o),
  .oe_n_o      (oe_n_o),
  .we_n_o      (we_n_o),
  .bus_addr_o  (bus_addr_o),
  .bus_dq_o    (bus_dq_o),
  .bus_dq_oe_o (bus_dq_oe_o),
  .ext_wait_ni (ext_wait_ni)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;
  localparam int AW = 22;
  localparam int DW = 32;
  localparam int BL = 4;
  localparam int BB = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mux_en = 1'b0, wait_en = 1'b0, req = 1'b0;
  logic          req_we = 1'b0, req_burst = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, wack, rvalid, done;
  logic [DW-1:0] rdata;
  logic          bank_cs_n, io_cs_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;
  logic          wait_n = 1'b1;

  always #5 clk = ~clk;

  mux_bus_master i_mux_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .mux_en_i(mux_en), .wait_en_i(wait_en),
    .req_i(req), .req_we_i(req_we), .req_burst_i(req_burst), .req_io_i(req_io),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready),
    .wdata_ack_o(wack), .rdata_o(rdata), .rvalid_o(rvalid), .done_o(done),
    .bank_cs_n_o(bank_cs_n), .io_cs_n_o(io_cs_n), .oe_n_o(oe_n), .we_n_o(we_n),
    .bus_addr_o(bus_addr), .bus_dq_o(dq_out), .bus_dq_oe_o(dq_oe),
    .bus_dq_i(dq_in), .ext_wait_ni(wait_n)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit timed_out = 0;
  always @(posedge clk) cyc++;

  // per-access model state
  bit            cur_we, cur_burst, cur_io, cur_mux, cur_eff;
  logic [AW-1:0] cur_addr, dev_base;
  int            exp_beats, wmode, wbudget, wr_idx;
  logic [DW-1:0] wd [BL];
  int            m_addrph, m_cs, m_stall, m_beats, m_rv, m_addr_bad;
  bit            m_done, m_done_ok, m_flag_bad, m_cs_bad, m_oe_bad;
  logic [DW-1:0] m_rd [BL];
  logic [DW-1:0] m_wr [BL];

  function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
    return {a[9:0], a} ^ 32'h1357_9bdf;
  endfunction

  function automatic logic [AW-1:0] flagged(input logic [AW-1:0] a, input bit b);
    logic [AW-1:0] r;
    r = a;
    r[BB] = b;
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // device model and requester drive at the falling edge
  always @(negedge clk) begin
    if (cur_mux) dq_in <= dev_word(dev_base + AW'(m_beats));
    else         dq_in <= dev_word(bus_addr);
    if (wr_idx < BL) req_wdata <= wd[wr_idx];
    case (wmode)
      1: wait_n <= (($urandom % 10) >= 3);
      2: wait_n <= 1'b0;
      3: if ((!oe_n || !we_n) && wbudget > 0) begin
           wait_n <= 1'b0;
           wbudget--;
         end else wait_n <= 1'b1;
      default: wait_n <= 1'b1;
    endcase
  end

  // monitor samples just before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (req && ready) wr_idx++;
    if (wack) wr_idx++;
    if (!bank_cs_n || !io_cs_n) begin
      m_cs++;
      if (cur_io ? !bank_cs_n : !io_cs_n) m_cs_bad = 1;
      if (oe_n && we_n) begin
        m_addrph++;
        if (bus_addr[BB] !== cur_burst || dq_out[BB] !== cur_burst || !dq_oe) m_flag_bad = 1;
        dev_base = dq_out[AW-1:0];
        dev_base[BB] = 1'b0;
      end else begin
        if (!oe_n && dq_oe) m_oe_bad = 1;
        if (!we_n && !dq_oe) m_oe_bad = 1;
        if (!wait_n && cur_eff) m_stall++;
        else begin
          if (bus_addr !== (cur_mux ? flagged(cur_addr, cur_burst) : cur_addr + AW'(m_beats)))
            m_addr_bad++;
          if (!we_n && m_beats < BL) m_wr[m_beats] = dq_out;
          m_beats++;
        end
      end
    end
    if (rvalid) begin
      if (m_rv < BL) m_rd[m_rv] = rdata;
      m_rv++;
    end
    if (done) begin
      m_done = 1;
      m_done_ok = ready && (cur_we || (rvalid && m_rv == exp_beats));
    end
  end

  task automatic do_acc(input bit we, input bit burst, input bit io, input bit mux,
                        input bit wen, input logic [AW-1:0] a, input int wm);
    logic [AW-1:0] eb;
    string tcyc;
    cur_we = we; cur_burst = burst; cur_io = io;
    cur_mux = mux && !io; cur_eff = wen || io; cur_addr = a;
    exp_beats = burst ? BL : 1;
    m_addrph = 0; m_cs = 0; m_stall = 0; m_beats = 0; m_rv = 0; m_addr_bad = 0;
    m_done = 0; m_done_ok = 0; m_flag_bad = 0; m_cs_bad = 0; m_oe_bad = 0;
    for (int i = 0; i < BL; i++) begin
      wd[i] = $urandom;
      m_rd[i] = '0;
      m_wr[i] = '0;
    end
    wr_idx = 0; wmode = wm; wbudget = 3;
    @(negedge clk);
    mux_en = mux; wait_en = wen; req_we = we; req_burst = burst; req_io = io;
    req_addr = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    mux_en = $urandom; wait_en = $urandom;
    while (!m_done && cyc < 150000) @(negedge clk);
    if (!m_done) begin
      timed_out = 1;
      return;
    end
    eb = cur_mux ? flagged(a, 1'b0) : a;
    chk(m_addrph == (cur_mux ? 1 : 0), cur_mux ? "R1" : "R2", "address cycles", m_addrph, cur_mux);
    if (cur_mux) chk(!m_flag_bad, "R4", "burst flag in address cycle", m_flag_bad, 0);
    chk(m_beats == exp_beats, "R3", "beat count", m_beats, exp_beats);
    chk(m_addr_bad == 0, cur_mux ? "R3" : "R2", "address per beat", m_addr_bad, 0);
    tcyc = io ? "R7" : (wen ? "R5" : "R6");
    chk(m_cs == (cur_mux ? 1 : 0) + exp_beats + m_stall, tcyc, "select cycles",
        m_cs, (cur_mux ? 1 : 0) + exp_beats + m_stall);
    chk(!m_cs_bad, "R7", "chip select choice", m_cs_bad, 0);
    chk(!m_oe_bad, "R10", "data line direction", m_oe_bad, 0);
    chk(m_done_ok, "R9", "done timing", m_done_ok, 1);
    if (we) begin
      chk(m_rv == 0, "R8", "no read strobe on write", m_rv, 0);
      for (int i = 0; i < exp_beats; i++)
        chk(m_wr[i] == wd[i], "R10", "write word", m_wr[i], wd[i]);
    end else begin
      chk(m_rv == exp_beats, "R8", "read strobes", m_rv, exp_beats);
      for (int i = 0; i < exp_beats; i++)
        chk(m_rd[i] == dev_word(eb + AW'(i)), "R8", "read word", m_rd[i], dev_word(eb + AW'(i)));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    wmode = 0;
    wr_idx = BL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    // R11 reset state
    chk(ready && bank_cs_n && io_cs_n && oe_n && we_n && !dq_oe && !rvalid && !done,
        "R11", "idle after reset",
        {ready, bank_cs_n, io_cs_n, oe_n, we_n, dq_oe, rvalid, done}, 8'b1111_1000);

    // directed corners
    do_acc(0, 0, 0, 1, 0, 22'h2A_1234, 0);  // R1 single mux read, bit 21 set in request
    do_acc(0, 1, 0, 1, 0, 22'h01_0FFE, 0);  // R3 R4 mux burst read
    do_acc(1, 0, 0, 0, 0, 22'h3F_FFFF, 0);  // R2 plain single write
    do_acc(0, 1, 0, 0, 0, 22'h3F_FFFE, 0);  // R2 R3 plain burst read across wrap
    do_acc(1, 1, 0, 1, 1, 22'h00_0040, 1);  // R10 mux burst write with waits
    do_acc(0, 1, 0, 1, 0, 22'h12_3450, 2);  // R6 wait held low, disabled
    do_acc(0, 1, 0, 1, 1, 22'h05_5550, 3);  // R5 three wait cycles
    do_acc(0, 1, 1, 1, 0, 22'h07_0000, 3);  // R7 I/O honours wait regardless
    do_acc(1, 0, 1, 1, 0, 22'h07_0100, 1);  // R7 I/O never multiplexed

    for (int n = 0; n < 80 && !timed_out; n++) begin
      bit we, bu, io, mx, we_en;
      int wm;
      we = $urandom; bu = $urandom; io = ($urandom % 4) == 0;
      mx = $urandom; we_en = $urandom;
      wm = $urandom % 4;
      if (wm == 2 && (we_en || io)) wm = 1;
      do_acc(we, bu, io, mx, we_en, AW'($urandom), wm);
    end

    if (timed_out) chk(0, "R9", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule